// File: doc/BRIEF.md
# Serial Receive FIFO Register Interface

This block is the register-mapped control and status logic of a serial port. Incoming bytes arrive from an external deserializer as a byte with a valid strobe and are kept in a 16-entry circular receive queue. Software reads the queue through a data register and sees its fill level through a count register. A programmable trigger level (1, 4, 8 or 14 bytes) decides when the receive-full flag rises and, if enabled, when the level-sensitive receive interrupt goes high. Writing a byte to the transmit data register sends it out on a byte output with a one-cycle valid strobe. Bit-level serialization, baud timing and parity are handled elsewhere.

The status flags are cleared by writing 0 to their bit positions. A 1 in a bit leaves that flag alone. A status read re-arms both transmit flags whenever transmit is enabled. The bus is a simple synchronous port. A write takes effect at the clock edge. Read data is combinational in the cycle the read strobe is high, and any side effect of the read lands at the edge that closes that cycle.

The queue occupancy is tracked by a three-state machine with the states OCC_EMPTY, OCC_PART and OCC_FULL. Its transitions are:
- fill: OCC_EMPTY to OCC_PART on a stored byte.
- top-up: OCC_PART to OCC_FULL when the count reaches the depth.
- drain: OCC_FULL to OCC_PART on a read.
- last-out: OCC_PART to OCC_EMPTY when the count returns to zero.
- flush: any state to OCC_EMPTY.

Register offsets (hexadecimal):

| Offset | Register |
|---|---|
| 00 | mode |
| 08 | control |
| 0C | transmit data |
| 10 | status |
| 14 | receive data |
| 18 | FIFO control |
| 1C | count |

Top module: `sercom_rx_regif`

## Requirements
- R1: After reset, the control register reads 0x20 and the mode, FIFO-control and count registers read 0x00. The status register reads 0x60, meaning transmit-end (bit 6) and transmit-data-empty (bit 5) are set. rx_irq and tx_irq are low and the trigger level is 1.
- R2: Writes are masked: the mode register keeps value AND 0x7B and the control register keeps value AND 0xFA. Both read back the masked value.
- R3: In the FIFO-control register, bits 7:6 select the trigger level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. The written value reads back unchanged. Writing it with bit 1 set empties the queue (count 0) and clears receive-full.
- R4: While control bit 4 is set, an arriving byte is stored if the count is below 16, and the count rises by one. A byte arriving at count 16 is dropped.
- R5: While control bit 4 is clear, arriving bytes are ignored.
- R6: A read at 0x14 returns the oldest stored byte and lowers the count by one, so bytes come out in arrival order. A read at 0x14 with an empty queue returns 0x00 and changes nothing.
- R7: Receive-full (status bit 1) is set when an arrival brings the count to or above the trigger level. It is cleared when a read brings the count below the trigger level.
- R8: rx_irq is set together with receive-full when control bit 6 is set. It is cleared by a status write with 0 in bit 1 or bit 0, or by a control write with bit 6 clear.
- R9: A status write with 0 in bit 6, 5, 4 or 1 clears that flag, and a 1 leaves it unchanged. Bit 0 reads 0. A pulse on rx_break sets the break flag (bit 4).
- R10: A write at 0x0C raises tx_valid for exactly one cycle after the write edge, with tx_data equal to the written byte, and clears transmit-data-empty.
- R11: A status read while control bit 5 is set sets transmit-end and transmit-data-empty after the read. A control write with bit 5 clear sets transmit-end.
- R12: tx_irq follows control bit 7.
- R13: An arrival and a 0x14 read in the same cycle both take effect. The count is unchanged and receive-full is re-evaluated against that count.
- R14: A read at 0x1C returns the count. Storage pointers wrap from 15 to 0 without disturbing the order of the bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe, never high together with bus_wr |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, 0 otherwise |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break detected pulse |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_irq | output | 1 | Receive interrupt, level |
| tx_irq | output | 1 | Transmit interrupt, level |

## Verification
Read data belongs to the cycle in which the strobe is presented. The bench therefore drives a read at a falling edge and samples bus_rdata one nanosecond later, before the next rising edge. Writes, arrivals and break pulses take effect at the next rising edge. Their results (register contents, count, flags, rx_irq and tx_irq) are due one cycle after the stimulus, and the bench checks them at the falling edge that follows that rising edge. tx_valid is checked in that same half-cycle and again one cycle later, to prove the pulse lasts exactly one cycle. The re-arming side effect of a status read only shows up in the next status read, so the bench checks it with back-to-back reads.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

    localparam int unsigned ADDR_W = 6;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MODE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_TXD  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_RXD  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_FCTL = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h1C;

    localparam logic [DATA_W-1:0] MODE_WMASK = 8'h7B;
    localparam logic [DATA_W-1:0] CTRL_WMASK = 8'hFA;
    localparam logic [DATA_W-1:0] CTRL_RST   = 8'h20;

    // control bits
    localparam int unsigned C_RXEN  = 4;
    localparam int unsigned C_TXEN  = 5;
    localparam int unsigned C_RXIE  = 6;
    localparam int unsigned C_TXIE  = 7;
    // status bits
    localparam int unsigned S_TEND  = 6;
    localparam int unsigned S_TDE   = 5;
    localparam int unsigned S_BRK   = 4;
    localparam int unsigned S_RDF   = 1;
    localparam int unsigned S_DR    = 0;
    // FIFO control bits
    localparam int unsigned F_FLUSH = 1;
    localparam int unsigned F_TRG_LO = 6;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/sercom_rx_fifo.sv
module sercom_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    input  logic             flush,
    output logic [WIDTH-1:0] head_data,
    output logic [CW-1:0]    count,
    output logic [CW-1:0]    next_count,
    output logic             push_ok,
    output logic             pop_ok
);
    import sercom_pkg::*;

    occ_e             occ_q, occ_nx;
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [WIDTH-1:0] store [DEPTH];
    logic             is_full, is_empty;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // output decode of occupancy state
    always_comb begin
        is_full  = 1'b0;
        is_empty = 1'b0;
        unique case (occ_q)
            OCC_EMPTY: is_empty = 1'b1;
            OCC_FULL:  is_full  = 1'b1;
            default:   ;
        endcase
    end

    assign push_ok    = push_req && !flush && !is_full;
    assign pop_ok     = pop_req  && !flush && !is_empty;
    assign next_count = flush ? '0 : (count + CW'(push_ok) - CW'(pop_ok));
    assign head_data  = store[rd_ptr];

    // transitions: fill, top-up, drain, last-out, flush
    always_comb begin
        occ_nx = occ_q;
        if (flush) begin
            occ_nx = OCC_EMPTY;
        end else begin
            unique case (occ_q)
                OCC_EMPTY: if (push_ok)
                    occ_nx = (next_count == CW'(DEPTH)) ? OCC_FULL : OCC_PART;
                OCC_PART: begin
                    if (next_count == '0)               occ_nx = OCC_EMPTY;
                    else if (next_count == CW'(DEPTH))  occ_nx = OCC_FULL;
                end
                OCC_FULL: if (pop_ok)
                    occ_nx = (next_count == '0) ? OCC_EMPTY : OCC_PART;
                default: occ_nx = OCC_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= OCC_EMPTY;
        else        occ_q <= occ_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= next_count;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= bump(wr_ptr);
                if (pop_ok)  rd_ptr <= bump(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) store[wr_ptr] <= push_data;
    end

    // R4: count never exceeds depth
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R4: arrival at full queue is dropped
    a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && push_req && !pop_req && !flush) |=> count == CW'(DEPTH));
    // R3: flush empties
    a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && occ_q == OCC_EMPTY));
    // R6: read of empty queue changes nothing
    a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop_req && !push_req && !flush) |=> count == '0);
    // R14: state machine agrees with the count
    a_r14_occ_full: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_FULL) == (count == CW'(DEPTH)));

endmodule

// File: rtl/sercom_flags.sv
module sercom_flags #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          irq_en,
    input  logic          ctrl_wr,
    input  logic          ctrl_wr_txen,
    input  logic          ctrl_wr_irqen,
    input  logic          stat_rd,
    input  logic [4:0]    stat_clr,     // {tend, tde, brk, rdf, dr}
    input  logic          txd_wr,
    input  logic          brk_in,
    input  logic          flush,
    input  logic          push_ok,
    input  logic          pop_ok,
    input  logic [CW-1:0] next_count,
    input  logic [CW-1:0] trig,
    output logic          tend,
    output logic          tde,
    output logic          brk,
    output logic          rdf,
    output logic          rx_irq
);
    logic tend_nx, tde_nx, brk_nx, rdf_nx, irq_nx;
    logic at_trig, irq_en_eff;

    assign at_trig    = (next_count >= trig);
    assign irq_en_eff = ctrl_wr ? ctrl_wr_irqen : irq_en;

    always_comb begin
        tend_nx = tend;
        if (ctrl_wr && !ctrl_wr_txen) tend_nx = 1'b1;
        if (stat_clr[4])              tend_nx = 1'b0;
        if (stat_rd && tx_en)         tend_nx = 1'b1;

        tde_nx = tde;
        if (txd_wr)                   tde_nx = 1'b0;
        if (stat_clr[3])              tde_nx = 1'b0;
        if (stat_rd && tx_en)         tde_nx = 1'b1;

        brk_nx = brk;
        if (stat_clr[2])              brk_nx = 1'b0;
        if (brk_in)                   brk_nx = 1'b1;

        rdf_nx = rdf;
        if (stat_clr[1] || flush)     rdf_nx = 1'b0;
        if (push_ok && at_trig)       rdf_nx = 1'b1;
        else if (pop_ok && !at_trig)  rdf_nx = 1'b0;

        irq_nx = rx_irq;
        if (stat_clr[1] || stat_clr[0])     irq_nx = 1'b0;
        if (ctrl_wr && !ctrl_wr_irqen)      irq_nx = 1'b0;
        if (push_ok && at_trig && irq_en_eff) irq_nx = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tend   <= 1'b1;
            tde    <= 1'b1;
            brk    <= 1'b0;
            rdf    <= 1'b0;
            rx_irq <= 1'b0;
        end else begin
            tend   <= tend_nx;
            tde    <= tde_nx;
            brk    <= brk_nx;
            rdf    <= rdf_nx;
            rx_irq <= irq_nx;
        end
    end

    // R7: receive-full only rises on a stored arrival
    a_r7_rdf_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdf) |-> $past(push_ok));
    // R8: interrupt rises together with receive-full
    a_r8_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> rdf);
    // R9: break pulse is captured
    a_r9_brk_capture: assert property (@(posedge clk) disable iff (!rst_n)
        brk_in |=> brk);
    // R10: transmit write empties the data flag
    a_r10_tde_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_wr && !(stat_rd && tx_en)) |=> !tde);
    // R11: status read re-arms transmit flags
    a_r11_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && tx_en) |=> (tde && tend));

endmodule

// File: rtl/sercom_rx_regif.sv
module sercom_rx_regif #(
    parameter int unsigned FIFO_DEPTH = 16,
    localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [5:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_break,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       rx_irq,
    output logic       tx_irq
);
    import sercom_pkg::*;

    logic [7:0]    mode_q, ctrl_q, fctl_q;
    logic          wr_mode, wr_ctrl, wr_txd, wr_stat, wr_fctl;
    logic          rd_stat, rd_rxd;
    logic          flush;
    logic [4:0]    stat_clr;
    logic [CW-1:0] trig, count, next_count;
    logic [7:0]    head_data;
    logic          push_ok, pop_ok;
    logic          f_tend, f_tde, f_brk, f_rdf;

    assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_txd  = bus_wr && (bus_addr == OFS_TXD);
    assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
    assign wr_fctl = bus_wr && (bus_addr == OFS_FCTL);
    assign rd_stat = bus_rd && (bus_addr == OFS_STAT);
    assign rd_rxd  = bus_rd && (bus_addr == OFS_RXD);

    assign flush = wr_fctl && bus_wdata[F_FLUSH];
    assign trig  = CW'(trig_level(fctl_q[F_TRG_LO +: 2]));

    assign stat_clr = {5{wr_stat}} & ~{bus_wdata[S_TEND], bus_wdata[S_TDE],
                                       bus_wdata[S_BRK],  bus_wdata[S_RDF],
                                       bus_wdata[S_DR]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            ctrl_q   <= CTRL_RST;
            fctl_q   <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            if (wr_mode) mode_q <= bus_wdata & MODE_WMASK;
            if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_WMASK;
            if (wr_fctl) fctl_q <= bus_wdata;
            tx_valid <= wr_txd;
            if (wr_txd) tx_data <= bus_wdata;
        end
    end

    assign tx_irq = ctrl_q[C_TXIE];

    sercom_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (rx_valid && ctrl_q[C_RXEN]),
        .push_data  (rx_data),
        .pop_req    (rd_rxd),
        .flush      (flush),
        .head_data  (head_data),
        .count      (count),
        .next_count (next_count),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok)
    );

    sercom_flags #(.CW(CW)) flags_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_en         (ctrl_q[C_TXEN]),
        .irq_en        (ctrl_q[C_RXIE]),
        .ctrl_wr       (wr_ctrl),
        .ctrl_wr_txen  (bus_wdata[C_TXEN]),
        .ctrl_wr_irqen (bus_wdata[C_RXIE]),
        .stat_rd       (rd_stat),
        .stat_clr      (stat_clr),
        .txd_wr        (wr_txd),
        .brk_in        (rx_break),
        .flush         (flush),
        .push_ok       (push_ok),
        .pop_ok        (pop_ok),
        .next_count    (next_count),
        .trig          (trig),
        .tend          (f_tend),
        .tde           (f_tde),
        .brk           (f_brk),
        .rdf           (f_rdf),
        .rx_irq        (rx_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_MODE: bus_rdata = mode_q;
                OFS_CTRL: bus_rdata = ctrl_q;
                OFS_STAT: bus_rdata = {1'b0, f_tend, f_tde, f_brk, 2'b00, f_rdf, 1'b0};
                OFS_RXD:  bus_rdata = (count != '0) ? head_data : 8'h00;
                OFS_FCTL: bus_rdata = fctl_q;
                OFS_CNT:  bus_rdata = 8'(count);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R1: bus strobes are exclusive
    a_r1_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));
    // R2: control write keeps only masked bits
    a_r2_ctrl_mask: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl_q & ~CTRL_WMASK) == 8'h00);
    // R5: disabled receiver ignores arrivals
    a_r5_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ctrl_q[C_RXEN] && !bus_rd && !wr_fctl) |=> $stable(count));
    // R10: transmit strobe follows the write by one cycle
    a_r10_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_txd |=> (tx_valid && tx_data == $past(bus_wdata)));
    // R12: transmit interrupt tracks the written enable
    a_r12_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> tx_irq == $past(bus_wdata[C_TXIE]));
    // R13: simultaneous arrival and read keep the count
    a_r13_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(count));

endmodule

// File: tb/sercom_rx_regif_tb.sv
module sercom_rx_regif_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_valid, rx_irq, tx_irq;
    logic [7:0] tx_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sercom_rx_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    localparam int OP_WR = 0, OP_RD = 1, OP_RX = 2;

    function automatic logic [31:0] vec(int req, int op, logic [5:0] a,
                                        logic [7:0] d, logic [7:0] e);
        return {4'(req), 2'(op), a, d, e, 4'h0};
    endfunction

    localparam int NV = 33;
    localparam logic [31:0] VEC [NV] = '{
        vec(2,  OP_WR, 6'h08, 8'hFF, 8'h00),  // R2 control mask
        vec(2,  OP_RD, 6'h08, 8'h00, 8'hFA),
        vec(2,  OP_WR, 6'h00, 8'hFF, 8'h00),  // R2 mode mask
        vec(2,  OP_RD, 6'h00, 8'h00, 8'h7B),
        vec(4,  OP_RX, 6'h00, 8'h11, 8'h00),  // R4 store
        vec(14, OP_RD, 6'h1C, 8'h00, 8'h01),  // R14 count
        vec(7,  OP_RD, 6'h10, 8'h00, 8'h62),  // R7 flag at trigger 1
        vec(4,  OP_RX, 6'h00, 8'h22, 8'h00),
        vec(4,  OP_RX, 6'h00, 8'h33, 8'h00),
        vec(14, OP_RD, 6'h1C, 8'h00, 8'h03),
        vec(6,  OP_RD, 6'h14, 8'h00, 8'h11),  // R6 order
        vec(6,  OP_RD, 6'h14, 8'h00, 8'h22),
        vec(14, OP_RD, 6'h1C, 8'h00, 8'h01),
        vec(6,  OP_RD, 6'h14, 8'h00, 8'h33),
        vec(6,  OP_RD, 6'h14, 8'h00, 8'h00),  // R6 empty read
        vec(14, OP_RD, 6'h1C, 8'h00, 8'h00),
        vec(7,  OP_RD, 6'h10, 8'h00, 8'h60),  // R7 cleared below trigger
        vec(3,  OP_WR, 6'h18, 8'h40, 8'h00),  // R3 trigger 4
        vec(3,  OP_RD, 6'h18, 8'h00, 8'h40),
        vec(4,  OP_RX, 6'h00, 8'hA1, 8'h00),
        vec(4,  OP_RX, 6'h00, 8'hA2, 8'h00),
        vec(4,  OP_RX, 6'h00, 8'hA3, 8'h00),
        vec(7,  OP_RD, 6'h10, 8'h00, 8'h60),  // R7 below 4
        vec(4,  OP_RX, 6'h00, 8'hA4, 8'h00),
        vec(7,  OP_RD, 6'h10, 8'h00, 8'h62),  // R7 reached 4
        vec(6,  OP_RD, 6'h14, 8'h00, 8'hA1),
        vec(7,  OP_RD, 6'h10, 8'h00, 8'h60),  // R7 dropped to 3
        vec(9,  OP_WR, 6'h10, 8'h00, 8'h00),  // R9 clear all
        vec(9,  OP_RD, 6'h10, 8'h00, 8'h00),
        vec(11, OP_RD, 6'h10, 8'h00, 8'h60),  // R11 re-armed
        vec(3,  OP_WR, 6'h18, 8'hC2, 8'h00),  // R3 flush, trigger 14
        vec(3,  OP_RD, 6'h1C, 8'h00, 8'h00),
        vec(3,  OP_RD, 6'h18, 8'h00, 8'hC2)
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rx(logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rx_and_rd(logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; bus_rd = 1'b1; bus_addr = 6'h14;
        #1 q = bus_rdata;
        @(negedge clk);
        rx_valid = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h08, q); check("R1 ctrl", q, 8'h20);
        rd(6'h00, q); check("R1 mode", q, 8'h00);
        rd(6'h18, q); check("R1 fctl", q, 8'h00);
        rd(6'h1C, q); check("R1 count", q, 8'h00);
        rd(6'h10, q); check("R1 status", q, 8'h60);
        check("R1 rx_irq", {7'd0, rx_irq}, 8'h00);
        check("R1 tx_irq", {7'd0, tx_irq}, 8'h00);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[31:28], i);
            case (int'(v[27:26]))
                OP_WR: wr(v[25:20], v[19:12]);
                OP_RX: rx(v[19:12]);
                default: begin
                    rd(v[25:20], q);
                    check(tag, q, v[11:4]);
                end
            endcase
        end

        // R8 receive interrupt
        wr(6'h18, 8'h00);
        rx(8'h01);
        check("R8 irq set", {7'd0, rx_irq}, 8'h01);
        wr(6'h10, 8'hFE);
        check("R8 irq cleared by status bit0", {7'd0, rx_irq}, 8'h00);
        rd(6'h10, q); check("R8 flag kept", q & 8'h02, 8'h02);
        rx(8'h02);
        check("R8 irq set again", {7'd0, rx_irq}, 8'h01);
        wr(6'h08, 8'hBA);
        check("R8 irq cleared by enable", {7'd0, rx_irq}, 8'h00);
        wr(6'h08, 8'hFA);

        // R13 simultaneous arrival and read, trigger 4
        wr(6'h18, 8'h42);
        for (int i = 0; i < 4; i++) rx(8'(8'h40 + i));
        wr(6'h10, 8'hFD);
        rd(6'h10, q); check("R13 flag cleared first", q & 8'h02, 8'h00);
        rx_and_rd(8'h44, q); check("R13 oldest out", q, 8'h40);
        rd(6'h1C, q); check("R13 count kept", q, 8'h04);
        rd(6'h10, q); check("R13 flag re-evaluated", q & 8'h02, 8'h02);
        rd(6'h14, q); check("R13 order", q, 8'h41);

        // R3 flush clears flag
        wr(6'h18, 8'h00);
        rx(8'h09);
        wr(6'h18, 8'h02);
        rd(6'h10, q); check("R3 flush clears flag", q & 8'h02, 8'h00);
        rd(6'h1C, q); check("R3 flush count", q, 8'h00);

        // R4 overflow and R14 wrap
        for (int i = 0; i < 5; i++) rx(8'(i));
        for (int i = 0; i < 5; i++) rd(6'h14, q);
        for (int i = 0; i < 17; i++) rx(8'(8'h80 + i));
        rd(6'h1C, q); check("R4 full count", q, 8'd16);
        for (int i = 0; i < 16; i++) begin
            rd(6'h14, q); check($sformatf("R14 wrap order %0d", i), q, 8'(8'h80 + i));
        end
        rd(6'h14, q); check("R4 dropped byte absent", q, 8'h00);

        // R5 receiver disabled
        wr(6'h08, 8'hEA);
        rx(8'h77);
        rd(6'h1C, q); check("R5 ignored", q, 8'h00);
        wr(6'h08, 8'hFA);

        // R9 break and clear-by-zero
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
        wr(6'h10, 8'hFF);
        rd(6'h10, q); check("R9 ones keep flags", q, 8'h70);
        wr(6'h10, 8'hEF);
        rd(6'h10, q); check("R9 break cleared", q, 8'h60);

        // R12, R11, R10 transmit side
        wr(6'h08, 8'h5A);
        check("R12 tx_irq low", {7'd0, tx_irq}, 8'h00);
        wr(6'h10, 8'hBF);
        rd(6'h10, q); check("R11 tend cleared", q & 8'h40, 8'h00);
        wr(6'h08, 8'h5A);
        rd(6'h10, q); check("R11 tend set by ctrl", q & 8'h40, 8'h40);
        wr(6'h0C, 8'h5C);
        check("R10 tx_valid", {7'd0, tx_valid}, 8'h01);
        check("R10 tx_data", tx_data, 8'h5C);
        @(negedge clk);
        check("R10 single pulse", {7'd0, tx_valid}, 8'h00);
        rd(6'h10, q); check("R10 tde cleared", q & 8'h20, 8'h00);
        wr(6'h08, 8'hFA);
        check("R12 tx_irq high", {7'd0, tx_irq}, 8'h01);
        rd(6'h10, q); check("R11 tde before rearm", q & 8'h20, 8'h00);
        rd(6'h10, q); check("R11 tde rearmed", q & 8'h20, 8'h20);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule